// File: doc/BRIEF.md
# Fair Queued Hardware Lock Manager

This block keeps a set of lock semaphores on behalf of several processors. Every lock holds a busy flag and a first-in, first-out list of the processors that are waiting for it. Each processor owns one command port. On that port it asks to acquire or to release a lock, chosen by its index. A request for a free lock is granted at once. A request for a busy lock puts the requester at the tail of that lock's wait list. Releasing a lock that has waiters does not free it. Ownership goes directly to the oldest waiter, and the unit tells that processor so through a directed unblock message.

A fixed-priority arbiter takes in at most one command per cycle. Each command tests and updates the lock state in a single step, so no other command can fall between the test and the update. Each accepted command produces a registered response one cycle later. The response carries the processor number and an outcome code. The unblock message leaves on a valid/ready port. While that port is stalled, the unit accepts no new commands. Waking the processor when its message arrives is left to the logic that receives the message.

Top module: `fairlock_unit`

## Requirements
- R1: After reset every lock is free and its wait list is empty. `rsp_valid` and `ub_valid` are 0.
- R2: An acquire (`cmd_op`=0) on a free lock marks the lock busy and responds with code 0 (granted).
- R3: An acquire on a busy lock appends the requester to that lock's wait list and responds with code 1 (queued). The lock stays busy.
- R4: A release (`cmd_op`=1) on a busy lock with an empty wait list frees the lock and responds with code 2 (freed).
- R5: A release on a busy lock with waiters removes the oldest waiter and responds with code 3 (handed over). In the following cycle `ub_valid` rises, with `ub_pid` set to that waiter and `ub_lock` set to the lock. The lock stays busy.
- R6: Waiters on one lock are handed the lock in the exact order in which their acquires were accepted.
- R7: At most one command is accepted per cycle (`cmd_ready` is one-hot or zero). Among valid requesters, the lowest-numbered port wins.
- R8: While `ub_valid` is 1 and `ub_ready` is 0, no command is accepted, and `ub_pid` and `ub_lock` hold steady.
- R9: A release on a free lock responds with code 4 (error) and changes no lock state.
- R10: Every accepted command yields exactly one response in the next cycle, with `rsp_pid` equal to the accepting port's number and `rsp_lock` equal to its lock index. There is no response in a cycle that follows no acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NPROC | Per-processor command request |
| cmd_op | input | NPROC | Per-processor operation: 0 acquire, 1 release |
| cmd_lock | input | NPROC*LW | Per-processor lock index, port i in bits [i*LW +: LW] |
| cmd_ready | output | NPROC | Per-processor acceptance strobe |
| rsp_valid | output | 1 | Response present |
| rsp_pid | output | PIDW | Processor the response belongs to |
| rsp_code | output | 3 | 0 granted, 1 queued, 2 freed, 3 handed over, 4 error |
| rsp_lock | output | LW | Lock index of the answered command |
| ub_valid | output | 1 | Unblock message present |
| ub_pid | output | PIDW | Processor that now owns the lock |
| ub_lock | output | LW | Lock that was handed over |
| ub_ready | input | 1 | Receiver takes the unblock message |

## Verification
The bench builds the unit with four processors and only four locks, so that random traffic often meets busy locks. Under these values wait lists fill up to three deep, which exercises the wrap-around of their read and write pointers. The random mix also includes releases of free locks, which reach the error path. Directed sequences cover simultaneous requests on three ports, an unblock port held stalled for several cycles, and a chain of three waiters handed one lock in turn.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam logic OP_ACQ = 1'b0;
  localparam logic OP_REL = 1'b1;

  typedef enum logic [2:0] {
    RSP_GRANT   = 3'd0,
    RSP_QUEUED  = 3'd1,
    RSP_FREED   = 3'd2,
    RSP_HANDOFF = 3'd3,
    RSP_ERROR   = 3'd4
  } rsp_code_e;
endpackage

// File: rtl/fl_prio_arb.sv
module fl_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic seen;
  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !seen;
      seen   = seen || req[i];
    end
  end
endmodule

// File: rtl/fl_cmd_select.sv
module fl_cmd_select #(
  parameter int NPROC = 4,
  parameter int LW    = 3,
  localparam int PIDW = $clog2(NPROC)
) (
  input  logic [NPROC-1:0]    gnt,
  input  logic [NPROC-1:0]    ops,
  input  logic [NPROC*LW-1:0] locks,
  output logic                sel_op,
  output logic [LW-1:0]       sel_lock,
  output logic [PIDW-1:0]     sel_pid
);
  always_comb begin
    sel_op   = 1'b0;
    sel_lock = '0;
    sel_pid  = '0;
    for (int i = 0; i < NPROC; i++) begin
      if (gnt[i]) begin
        sel_op   = sel_op | ops[i];
        sel_lock = sel_lock | locks[i*LW +: LW];
        sel_pid  = sel_pid | PIDW'(i);
      end
    end
  end
endmodule

// File: rtl/fl_lock_table.sv
module fl_lock_table
  import fl_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NLOCK = 8,
  localparam int PIDW = $clog2(NPROC),
  localparam int LW   = $clog2(NLOCK),
  localparam int CW   = $clog2(NPROC + 1),
  localparam int SW   = PIDW + 2,
  localparam int AW   = $clog2(NLOCK * NPROC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_en,
  input  logic            op_kind,
  input  logic [LW-1:0]   op_lock,
  input  logic [PIDW-1:0] op_pid,
  output rsp_code_e       op_result,
  output logic [PIDW-1:0] deq_pid
);
  localparam logic [CW-1:0]   DEPTH_C = CW'(NPROC);
  localparam logic [PIDW-1:0] LAST_P  = PIDW'(NPROC - 1);

  logic [NLOCK-1:0] busy_q;
  logic [PIDW-1:0]  head_q [NLOCK];
  logic [CW-1:0]    cnt_q  [NLOCK];
  logic [PIDW-1:0]  wait_mem [NLOCK*NPROC];

  logic            cur_busy;
  logic [PIDW-1:0] cur_head;
  logic [CW-1:0]   cur_cnt;
  logic [SW-1:0]   tail_sum;
  logic [PIDW-1:0] tail_ptr;
  logic [AW-1:0]   wr_addr;
  logic [AW-1:0]   rd_addr;
  logic            wr_en;

  assign cur_busy = busy_q[op_lock];
  assign cur_head = head_q[op_lock];
  assign cur_cnt  = cnt_q[op_lock];

  always_comb begin
    tail_sum = SW'(cur_head) + SW'(cur_cnt);
    if (tail_sum >= SW'(NPROC)) tail_sum = tail_sum - SW'(NPROC);
    tail_ptr = tail_sum[PIDW-1:0];
  end

  assign wr_addr = AW'(op_lock) * AW'(NPROC) + AW'(tail_ptr);
  assign rd_addr = AW'(op_lock) * AW'(NPROC) + AW'(cur_head);
  assign deq_pid = wait_mem[rd_addr];

  always_comb begin
    op_result = RSP_GRANT;
    wr_en     = 1'b0;
    if (op_kind == OP_ACQ) begin
      if (!cur_busy) begin
        op_result = RSP_GRANT;
      end else if (cur_cnt < DEPTH_C) begin
        op_result = RSP_QUEUED;
        wr_en     = op_en;
      end else begin
        op_result = RSP_ERROR;
      end
    end else begin
      if (!cur_busy)             op_result = RSP_ERROR;
      else if (cur_cnt == '0)    op_result = RSP_FREED;
      else                       op_result = RSP_HANDOFF;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) wait_mem[wr_addr] <= op_pid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      for (int i = 0; i < NLOCK; i++) begin
        head_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (op_en) begin
      case (op_result)
        RSP_GRANT:   busy_q[op_lock] <= 1'b1;
        RSP_QUEUED:  cnt_q[op_lock]  <= cur_cnt + CW'(1);
        RSP_FREED:   busy_q[op_lock] <= 1'b0;
        RSP_HANDOFF: begin
          cnt_q[op_lock]  <= cur_cnt - CW'(1);
          head_q[op_lock] <= (cur_head == LAST_P) ? '0 : cur_head + PIDW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fairlock_unit.sv
module fairlock_unit
  import fl_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NLOCK = 8,
  localparam int PIDW = $clog2(NPROC),
  localparam int LW   = $clog2(NLOCK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPROC-1:0]    cmd_valid,
  input  logic [NPROC-1:0]    cmd_op,
  input  logic [NPROC*LW-1:0] cmd_lock,
  output logic [NPROC-1:0]    cmd_ready,
  output logic                rsp_valid,
  output logic [PIDW-1:0]     rsp_pid,
  output logic [2:0]          rsp_code,
  output logic [LW-1:0]       rsp_lock,
  output logic                ub_valid,
  output logic [PIDW-1:0]     ub_pid,
  output logic [LW-1:0]       ub_lock,
  input  logic                ub_ready
);
  logic             can_take;
  logic [NPROC-1:0] arb_req;
  logic [NPROC-1:0] arb_gnt;
  logic             take;
  logic             sel_op;
  logic [LW-1:0]    sel_lock;
  logic [PIDW-1:0]  sel_pid;
  rsp_code_e        result;
  logic [PIDW-1:0]  deq_pid;

  assign can_take  = !ub_valid || ub_ready;
  assign arb_req   = cmd_valid & {NPROC{can_take}};
  assign cmd_ready = arb_gnt;
  assign take      = |arb_gnt;

  fl_prio_arb #(.N(NPROC)) arb_i (
    .req (arb_req),
    .gnt (arb_gnt)
  );

  fl_cmd_select #(.NPROC(NPROC), .LW(LW)) sel_i (
    .gnt      (arb_gnt),
    .ops      (cmd_op),
    .locks    (cmd_lock),
    .sel_op   (sel_op),
    .sel_lock (sel_lock),
    .sel_pid  (sel_pid)
  );

  fl_lock_table #(.NPROC(NPROC), .NLOCK(NLOCK)) tbl_i (
    .clk       (clk),
    .rst       (rst),
    .op_en     (take),
    .op_kind   (sel_op),
    .op_lock   (sel_lock),
    .op_pid    (sel_pid),
    .op_result (result),
    .deq_pid   (deq_pid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_pid   <= '0;
      rsp_code  <= '0;
      rsp_lock  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_pid  <= sel_pid;
        rsp_code <= result;
        rsp_lock <= sel_lock;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ub_valid <= 1'b0;
      ub_pid   <= '0;
      ub_lock  <= '0;
    end else if (take && result == RSP_HANDOFF) begin
      ub_valid <= 1'b1;
      ub_pid   <= deq_pid;
      ub_lock  <= sel_lock;
    end else if (ub_ready) begin
      ub_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fairlock_chk.sv
module fairlock_chk #(
  parameter int NPROC = 4,
  parameter int NLOCK = 8,
  localparam int PIDW = $clog2(NPROC),
  localparam int LW   = $clog2(NLOCK)
) (
  input logic             clk,
  input logic             rst,
  input logic [NPROC-1:0] cmd_valid,
  input logic [NPROC-1:0] cmd_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_code,
  input logic             ub_valid,
  input logic [PIDW-1:0]  ub_pid,
  input logic [LW-1:0]    ub_lock,
  input logic             ub_ready
);
  p_ready_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_ready));

  p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready & ~cmd_valid) == '0);

  for (genvar i = 1; i < NPROC; i++) begin : g_prio
    p_prio_r7: assert property (@(posedge clk) disable iff (rst)
      cmd_ready[i] |-> (cmd_valid[i-1:0] == '0));
  end

  p_stall_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (ub_valid && !ub_ready) |-> (cmd_ready == '0));

  p_ub_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ub_valid && !ub_ready) |=> (ub_valid && $stable(ub_pid) && $stable(ub_lock)));

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready != '0) |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready == '0) |=> !rsp_valid);

  p_handoff_msg_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'd3) |-> ub_valid);
endmodule

bind fairlock_unit fairlock_chk #(.NPROC(NPROC), .NLOCK(NLOCK)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .ub_valid  (ub_valid),
  .ub_pid    (ub_pid),
  .ub_lock   (ub_lock),
  .ub_ready  (ub_ready)
);

// File: tb/fairlock_unit_tb_top.sv
`timescale 1ns/1ps
module fairlock_unit_tb_top;
  localparam int NP = 4;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int PW = 2;

  localparam int C_GRANT = 0, C_QUEUED = 1, C_FREED = 2, C_HAND = 3, C_ERR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    cmd_valid = '0;
  logic [NP-1:0]    cmd_op = '0;
  logic [NP*LW-1:0] cmd_lock = '0;
  logic [NP-1:0]    cmd_ready;
  logic             rsp_valid;
  logic [PW-1:0]    rsp_pid;
  logic [2:0]       rsp_code;
  logic [LW-1:0]    rsp_lock;
  logic             ub_valid;
  logic [PW-1:0]    ub_pid;
  logic [LW-1:0]    ub_lock;
  logic             ub_ready = 1'b1;

  always #4 clk = ~clk;

  fairlock_unit #(.NPROC(NP), .NLOCK(NL)) dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // reference model
  bit m_busy [NL];
  int m_q    [NL][NP];
  int m_head [NL];
  int m_cnt  [NL];
  int p_hold [NP];
  bit p_wait [NP];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_apply(input int p, input int op, input int l,
                             output int code, output int ubp);
    ubp = -1;
    if (op == 0) begin
      if (!m_busy[l]) begin
        m_busy[l] = 1'b1; code = C_GRANT; p_hold[p] = l;
      end else begin
        m_q[l][(m_head[l] + m_cnt[l]) % NP] = p;
        m_cnt[l]++; code = C_QUEUED; p_wait[p] = 1'b1;
      end
    end else begin
      if (!m_busy[l]) begin
        code = C_ERR;
      end else if (m_cnt[l] == 0) begin
        m_busy[l] = 1'b0; code = C_FREED;
        if (p_hold[p] == l) p_hold[p] = -1;
      end else begin
        ubp = m_q[l][m_head[l]];
        m_head[l] = (m_head[l] + 1) % NP;
        m_cnt[l]--; code = C_HAND;
        if (p_hold[p] == l) p_hold[p] = -1;
        p_hold[ubp] = l; p_wait[ubp] = 1'b0;
      end
    end
  endtask

  function automatic string code_tag(input int code);
    case (code)
      C_GRANT:  return "R2";
      C_QUEUED: return "R3";
      C_FREED:  return "R4";
      C_HAND:   return "R5";
      default:  return "R9";
    endcase
  endfunction

  // check response (and unblock output) at the negedge after acceptance
  task automatic check_rsp(input int p, input int op, input int l, input string tag);
    int code, ubp;
    string t;
    model_apply(p, op, l, code, ubp);
    t = (tag == "") ? code_tag(code) : tag;
    chk(rsp_valid == 1'b1, "R10 rsp_valid", rsp_valid, 1);
    chk(rsp_pid == PW'(p), "R10 rsp_pid", rsp_pid, p);
    chk(rsp_lock == LW'(l), "R10 rsp_lock", rsp_lock, l);
    chk(rsp_code == 3'(code), {t, " rsp_code"}, rsp_code, code);
    if (ubp >= 0) begin
      chk(ub_valid == 1'b1, {t, " ub_valid"}, ub_valid, 1);
      chk(ub_pid == PW'(ubp), {t, " ub_pid"}, ub_pid, ubp);
      chk(ub_lock == LW'(l), {t, " ub_lock"}, ub_lock, l);
    end else begin
      chk(ub_valid == 1'b0, {t, " no ub"}, ub_valid, 0);
    end
  endtask

  // called at a negedge with no other request pending
  task automatic do_cmd(input int p, input int op, input int l, input string tag);
    cmd_valid[p] = 1'b1;
    cmd_op[p]    = op[0];
    cmd_lock[p*LW +: LW] = LW'(l);
    #1;
    chk(cmd_ready == NP'(1 << p), "R7 ready", cmd_ready, 1 << p);
    @(posedge clk);
    @(negedge clk);
    cmd_valid[p] = 1'b0;
    check_rsp(p, op, l, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) begin
      m_busy[i] = 0; m_head[i] = 0; m_cnt[i] = 0;
    end
    for (int i = 0; i < NP; i++) begin
      p_hold[i] = -1; p_wait[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(ub_valid == 1'b0, "R1 ub_valid", ub_valid, 0);
    chk(cmd_ready == '0, "R1 ready idle", cmd_ready, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 no rsp idle", rsp_valid, 0);

    // R1: every lock free after reset
    for (int l = 0; l < NL; l++) begin
      do_cmd(0, 0, l, "R1");
      do_cmd(0, 1, l, "R4");
    end

    // R6: FIFO handover chain on lock 1
    do_cmd(0, 0, 1, "R2");
    do_cmd(3, 0, 1, "R3");
    do_cmd(1, 0, 1, "R3");
    do_cmd(2, 0, 1, "R3");
    do_cmd(0, 1, 1, "R6");
    do_cmd(3, 1, 1, "R6");
    do_cmd(1, 1, 1, "R6");
    do_cmd(2, 1, 1, "R4");

    // R9: release of free lock, state unchanged
    do_cmd(1, 0, 2, "R2");
    do_cmd(0, 1, 3, "R9");
    do_cmd(0, 0, 3, "R9 still free");
    do_cmd(3, 0, 2, "R9 other busy");
    do_cmd(1, 1, 2, "R5");
    do_cmd(3, 1, 2, "R4");
    do_cmd(0, 1, 3, "R4");

    // R7: simultaneous requesters, lowest index first
    for (int p = 1; p < NP; p++) begin
      cmd_valid[p] = 1'b1; cmd_op[p] = 1'b0;
      cmd_lock[p*LW +: LW] = LW'(p);
    end
    for (int p = 1; p < NP; p++) begin
      #1;
      chk(cmd_ready == NP'(1 << p), "R7 priority", cmd_ready, 1 << p);
      @(posedge clk);
      @(negedge clk);
      cmd_valid[p] = 1'b0;
      check_rsp(p, 0, p, "R7");
    end
    for (int p = 1; p < NP; p++) do_cmd(p, 1, p, "R4");

    // R8: stalled unblock port blocks commands
    ub_ready = 1'b0;
    do_cmd(0, 0, 0, "R2");
    do_cmd(1, 0, 0, "R3");
    do_cmd(0, 1, 0, "R5");
    cmd_valid[2] = 1'b1; cmd_op[2] = 1'b0; cmd_lock[2*LW +: LW] = LW'(2);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(cmd_ready == '0, "R8 stalled ready", cmd_ready, 0);
      chk(ub_valid == 1'b1 && ub_pid == PW'(1) && ub_lock == LW'(0),
          "R8 ub held", ub_pid, 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 no rsp stalled", rsp_valid, 0);
    end
    ub_ready = 1'b1;
    #1;
    chk(cmd_ready == NP'(4), "R8 resume", cmd_ready, 4);
    @(posedge clk);
    @(negedge clk);
    cmd_valid[2] = 1'b0;
    check_rsp(2, 0, 2, "R8");
    do_cmd(1, 1, 0, "R4");
    do_cmd(2, 1, 2, "R4");

    // constrained random traffic
    for (int it = 0; it < 4000; it++) begin
      int p, l;
      p = int'($urandom % NP);
      if (p_wait[p]) continue;
      if (p_hold[p] >= 0) begin
        do_cmd(p, 1, p_hold[p], "");
      end else begin
        l = int'($urandom % NL);
        if (($urandom % 8) == 0 && !m_busy[l]) do_cmd(p, 1, l, "R9");
        else do_cmd(p, 0, l, "");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule